// File: doc/BRIEF.md
# Display Panel Bring-Up Sequencer

This block wakes up a display panel that is configured over a write-only serial link: a clock, a data line, an active-low chip select and a separate line telling the panel whether the current byte is a command or a parameter. Once system reset is released, the block holds the panel's own reset pin low for a timed interval. It then releases that pin and waits a settling interval. After that it steps through a fixed script held in a small ROM. Each script entry is a command byte, a parameter byte, a millisecond pause or the end marker.

Every byte goes out as its own framed transfer. Chip select falls, eight bits are shifted most significant bit first in SPI mode 0, and chip select rises again. The command/parameter line is set before the frame starts and does not move until the frame has ended. A pause entry keeps the link idle for its millisecond count, measured with a tick derived from the system clock frequency parameter. At the end marker the done flag rises and stays high until the next reset.

The controller is a single state machine with these states:
- `ST_PRST_LOW`: the panel reset pin is held low.
- `ST_PRST_WAIT`: the pin has been released and the settling interval is running.
- `ST_FETCH`: the current script entry is decoded.
- `ST_LAUNCH`: a transfer is started.
- `ST_SHIFT`: the block waits for the transfer to finish.
- `ST_PAUSE`: a pause entry is counting down.
- `ST_DONE`: the script is complete.

The transitions are:
- `ST_PRST_LOW` goes to `ST_PRST_WAIT` when its time expires.
- `ST_PRST_WAIT` goes to `ST_FETCH` when its time expires.
- `ST_FETCH` goes to `ST_LAUNCH` for a command or parameter entry, to `ST_PAUSE` for a pause entry, and to `ST_DONE` for the end marker.
- `ST_LAUNCH` always goes to `ST_SHIFT`.
- `ST_SHIFT` goes to `ST_FETCH` once the transfer has finished.
- `ST_PAUSE` goes to `ST_FETCH` when its time expires.
- `ST_DONE` is left only by reset.

Top module: `panel_init_seq`

## Requirements
- R1: After reset release, `panel_rst_n` stays low for RST_LOW_MS milliseconds (50 by default), then goes high. No frame begins until RST_WAIT_MS milliseconds (20 by default) after that rising edge. While `panel_rst_n` is low, `cs_n` stays high.
- R2: A command byte is framed with `dc` = 0 and a parameter byte with `dc` = 1. `dc` does not change while `cs_n` is low.
- R3: Each byte has its own frame. `cs_n` falls, exactly eight rising edges of `sck` follow, and `cs_n` rises. `mosi` carries the byte most significant bit first and is sampled on the rising edge of `sck`.
- R4: SPI mode 0 timing. `sck` is low whenever `cs_n` is high. `mosi` holds steady while `sck` is high. Every high phase of `sck` lasts HALF_DIV clock cycles.
- R5: The script is sent in this order:
  - command 0x01, then a 10 ms pause;
  - command 0x3A, then parameter 0x55 (16-bit RGB565);
  - command 0x36, then parameter 0x08;
  - command 0x11, then a 100 ms pause;
  - command 0x29, then a 100 ms pause;
  - end.
- R6: During a pause entry no frame is produced. The idle time between the surrounding frames is at least the pause length.
- R7: One millisecond is CLK_HZ/1000 clock cycles. Every timed interval is that count multiplied by its millisecond value, plus a fixed overhead of a few cycles.
- R8: `done` rises after the final pause ends. It then stays high, with no further frames, until reset.
- R9: Between consecutive frames, `cs_n` stays high for at least one `sck` period (2·HALF_DIV cycles). `dc` already holds its new value when `cs_n` falls.
- R10: Asserting `rst_n` at any point forces `cs_n`=1, `sck`=0, `panel_rst_n`=0 and `done`=0. After release, the whole sequence restarts from the panel reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | output | 1 | Serial clock to the panel, idle low |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select, one frame per byte |
| dc | output | 1 | 0 = command byte, 1 = parameter byte |
| panel_rst_n | output | 1 | Active-low panel reset pin |
| done | output | 1 | Script finished; stays high until reset |

## Verification
The bound checker watches, on every cycle, the invariants that need no history beyond one clock:
- `sck` is idle whenever chip select is high;
- `mosi` is steady during a high `sck` phase;
- `dc` is frozen inside a frame;
- chip select stays quiet during the panel reset pulse and after `done`;
- `done` is sticky.

Only the bench's scenarios can show the rest. It decodes every frame and compares the byte values, their order and their `dc` values against the script. It measures the reset pulse, the settling time and each pause in clock cycles. It also shows that a reset arriving at a random point, even in the middle of a frame, restarts the whole bring-up cleanly.

// File: rtl/pis_pkg.sv
package pis_pkg;

    typedef enum logic [1:0] {
        E_CMD  = 2'd0,
        E_DATA = 2'd1,
        E_WAIT = 2'd2,
        E_END  = 2'd3
    } ekind_t;

    typedef struct packed {
        ekind_t      kind;
        logic [15:0] arg;
    } entry_t;

    localparam int SCRIPT_LEN = 11;

    function automatic entry_t script_at(input int unsigned i);
        entry_t e;
        case (i)
            0:       e = '{kind: E_CMD,  arg: 16'h0001};
            1:       e = '{kind: E_WAIT, arg: 16'd10};
            2:       e = '{kind: E_CMD,  arg: 16'h003A};
            3:       e = '{kind: E_DATA, arg: 16'h0055};
            4:       e = '{kind: E_CMD,  arg: 16'h0036};
            5:       e = '{kind: E_DATA, arg: 16'h0008};
            6:       e = '{kind: E_CMD,  arg: 16'h0011};
            7:       e = '{kind: E_WAIT, arg: 16'd100};
            8:       e = '{kind: E_CMD,  arg: 16'h0029};
            9:       e = '{kind: E_WAIT, arg: 16'd100};
            default: e = '{kind: E_END,  arg: 16'h0000};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pis_script_rom.sv
module pis_script_rom
    import pis_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output entry_t           entry
);
    always_comb entry = script_at(int'(idx));
endmodule

// File: rtl/pis_ms_tick.sv
module pis_ms_tick #(
    parameter int CYC_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pis_spi_tx.sv
module pis_spi_tx #(
    parameter int HALF_DIV = 4,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    output logic              fin,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n
);
    localparam int HW       = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HW-1:0] HLAST = HW'(HALF_DIV - 1);
    localparam int LAST_EDGE = 2 * BYTE_W;      // final falling edge slot
    localparam int CS_UP     = LAST_EDGE + 1;   // chip select release slot
    localparam int SLOT_END  = CS_UP + 3;       // one full sck period of gap
    localparam int SW        = $clog2(SLOT_END + 1);

    logic              busy;
    logic [SW-1:0]     slot;
    logic [SW-1:0]     nxt;
    logic [HW-1:0]     hc;
    logic [BYTE_W-1:0] sh;

    assign nxt = slot + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            slot <= '0;
            hc   <= '0;
            sh   <= '0;
            sck  <= 1'b0;
            mosi <= 1'b0;
            cs_n <= 1'b1;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    slot <= '0;
                    hc   <= '0;
                    sh   <= din;
                    mosi <= din[BYTE_W-1];
                    cs_n <= 1'b0;
                    sck  <= 1'b0;
                end
            end else if (hc != HLAST) begin
                hc <= hc + 1'b1;
            end else begin
                hc   <= '0;
                slot <= nxt;
                if (int'(nxt) <= LAST_EDGE && nxt[0]) begin
                    sck <= 1'b1;
                end else if (int'(nxt) <= LAST_EDGE) begin
                    sck <= 1'b0;
                    if (int'(nxt) != LAST_EDGE) begin
                        sh   <= {sh[BYTE_W-2:0], 1'b0};
                        mosi <= sh[BYTE_W-2];
                    end
                end else if (int'(nxt) == CS_UP) begin
                    cs_n <= 1'b1;
                    mosi <= 1'b0;
                end else if (int'(nxt) == SLOT_END) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import pis_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int HALF_DIV    = 4,
    parameter int RST_LOW_MS  = 50,
    parameter int RST_WAIT_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic sck,
    output logic mosi,
    output logic cs_n,
    output logic dc,
    output logic panel_rst_n,
    output logic done
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int IDX_W      = $clog2(SCRIPT_LEN);

    typedef enum logic [2:0] {
        ST_PRST_LOW, ST_PRST_WAIT, ST_FETCH, ST_LAUNCH,
        ST_SHIFT, ST_PAUSE, ST_DONE
    } state_t;

    state_t           state, state_n;
    logic [IDX_W-1:0] idx;
    logic [15:0]      ms_left, ms_val;
    logic             load_ms, idx_inc, tx_start, tx_fin, tick;
    entry_t           entry;

    pis_script_rom #(.IDX_W(IDX_W)) u_rom (.idx(idx), .entry(entry));

    pis_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(load_ms), .tick(tick)
    );

    pis_spi_tx #(.HALF_DIV(HALF_DIV), .BYTE_W(8)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .din(entry.arg[7:0]),
        .fin(tx_fin), .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    always_comb begin
        state_n  = state;
        load_ms  = 1'b0;
        ms_val   = '0;
        idx_inc  = 1'b0;
        tx_start = 1'b0;
        unique case (state)
            ST_PRST_LOW: if (ms_left == '0) begin
                state_n = ST_PRST_WAIT;
                load_ms = 1'b1;
                ms_val  = 16'(RST_WAIT_MS);
            end
            ST_PRST_WAIT: if (ms_left == '0) state_n = ST_FETCH;
            ST_FETCH: begin
                unique case (entry.kind)
                    E_CMD, E_DATA: state_n = ST_LAUNCH;
                    E_WAIT: begin
                        state_n = ST_PAUSE;
                        load_ms = 1'b1;
                        ms_val  = entry.arg;
                    end
                    E_END: state_n = ST_DONE;
                endcase
            end
            ST_LAUNCH: begin
                tx_start = 1'b1;
                state_n  = ST_SHIFT;
            end
            ST_SHIFT: if (tx_fin) begin
                state_n = ST_FETCH;
                idx_inc = 1'b1;
            end
            ST_PAUSE: if (ms_left == '0) begin
                state_n = ST_FETCH;
                idx_inc = 1'b1;
            end
            ST_DONE: state_n = ST_DONE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRST_LOW;
        else        state <= state_n;
    end

    // script pointer and millisecond countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_left <= 16'(RST_LOW_MS);
            idx     <= '0;
        end else begin
            if (load_ms)                     ms_left <= ms_val;
            else if (tick && ms_left != '0)  ms_left <= ms_left - 1'b1;
            if (idx_inc)                     idx <= idx + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc          <= 1'b0;
            panel_rst_n <= 1'b0;
            done        <= 1'b0;
        end else begin
            panel_rst_n <= (state_n != ST_PRST_LOW);
            done        <= (state_n == ST_DONE);
            if (state == ST_FETCH && (entry.kind == E_CMD || entry.kind == E_DATA))
                dc <= (entry.kind == E_DATA);
        end
    end
endmodule

// File: rtl/pis_checker.sv
module pis_checker (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic mosi,
    input logic cs_n,
    input logic dc,
    input logic panel_rst_n,
    input logic done
);
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R4
    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R4
    AST_DC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(dc)); // R2
    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> cs_n); // R1
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R8
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n); // R8
endmodule

bind panel_init_seq pis_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .dc(dc), .panel_rst_n(panel_rst_n), .done(done)
);

// File: tb/panel_init_seq_tb.sv
`timescale 1ns/1ps
module panel_init_seq_tb;
    localparam int CLK_HZ = 8000;
    localparam int HALF   = 2;
    localparam int C      = CLK_HZ / 1000;   // R7: cycles per millisecond
    localparam int NB     = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck, mosi, cs_n, dc, panel_rst_n, done;

    always #2 clk = ~clk;   // 250 MHz

    panel_init_seq #(.CLK_HZ(CLK_HZ), .HALF_DIV(HALF), .RST_LOW_MS(50), .RST_WAIT_MS(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .dc(dc), .panel_rst_n(panel_rst_n), .done(done)
    );

    int total = 0;
    int bad   = 0;

    function automatic int exp_byte(input int i);
        case (i)
            0: return 8'h01; 1: return 8'h3A; 2: return 8'h55; 3: return 8'h36;
            4: return 8'h08; 5: return 8'h11; default: return 8'h29;
        endcase
    endfunction
    function automatic int exp_dc(input int i);
        return (i == 2 || i == 4) ? 1 : 0;
    endfunction
    function automatic int wait_after(input int i);
        case (i)
            0: return 10; 5: return 100; 6: return 100; default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // frame monitor
    int cyc, nb, prst_rise, done_c, hiw, hw_bad, dc_bad, sh, bits;
    int byte_v[16], dc_v[16], bits_v[16], fall_c[16], rise_c[16];
    logic prev_cs, prev_sck, prev_dc;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; nb = 0; prst_rise = -1; done_c = -1; hiw = 0;
            hw_bad = 0; dc_bad = 0; sh = 0; bits = 0;
            prev_cs = 1'b1; prev_sck = 1'b0; prev_dc = 1'b0;
        end else begin
            cyc++;
            if (panel_rst_n && prst_rise < 0) prst_rise = cyc;
            if (done && done_c < 0) done_c = cyc;
            if (prev_cs && !cs_n && nb < 16) begin
                fall_c[nb] = cyc; dc_v[nb] = int'(dc); sh = 0; bits = 0;
            end
            if (!prev_cs && !cs_n && dc != prev_dc) dc_bad++;
            if (!prev_sck && sck) begin sh = ((sh << 1) | int'(mosi)) & 8'hFF; bits++; end
            if (sck) hiw++;
            if (prev_sck && !sck) begin
                if (hiw != HALF) hw_bad++;
                hiw = 0;
            end
            if (!prev_cs && cs_n && nb < 16) begin
                byte_v[nb] = sh; bits_v[nb] = bits; rise_c[nb] = cyc; nb++;
            end
            prev_cs = cs_n; prev_sck = sck; prev_dc = dc;
        end
    end

    task automatic run_full();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(cs_n === 1'b1 && sck === 1'b0 && panel_rst_n === 1'b0 && done === 1'b0,
            "R10 reset state", {cs_n, sck, panel_rst_n, done}, 4'b1000);
        rst_n = 1'b1;
        begin
            int w = 0;
            while (done !== 1'b1 && w < 40000) begin @(negedge clk); w++; end
            chk(done === 1'b1, "R8 done reached (watchdog)", w, 40000);
        end
        repeat (300) @(negedge clk);
        chk(prst_rise >= 50*C && prst_rise <= 50*C + 4, "R1 reset low time", prst_rise, 50*C);
        chk(fall_c[0] - prst_rise >= 20*C && fall_c[0] - prst_rise <= 20*C + 12,
            "R1 settle before first frame", fall_c[0] - prst_rise, 20*C);
        chk(nb == NB, "R5 frame count", nb, NB);
        for (int i = 0; i < NB && i < nb; i++) begin
            chk(byte_v[i] == exp_byte(i), "R5/R3 byte value", byte_v[i], exp_byte(i));
            chk(dc_v[i] == exp_dc(i), "R2 dc per byte", dc_v[i], exp_dc(i));
            chk(bits_v[i] == 8, "R3 edges per frame", bits_v[i], 8);
            if (i > 0) begin
                int g = fall_c[i] - rise_c[i-1];
                int w = wait_after(i-1);
                if (w > 0)
                    chk(g >= w*C && g <= w*C + 20, "R6/R7 pause length", g, w*C);
                else
                    chk(g >= 2*HALF, "R9 gap between frames", g, 2*HALF);
            end
        end
        if (nb >= NB)
            chk(done_c - rise_c[NB-1] >= 100*C && done_c - rise_c[NB-1] <= 100*C + 20,
                "R8 done after final pause", done_c - rise_c[NB-1], 100*C);
        chk(hw_bad == 0, "R4 sck high width", hw_bad, 0);
        chk(dc_bad == 0, "R2 dc stable in frame", dc_bad, 0);
        chk(done === 1'b1 && nb == NB, "R8 sticky and quiet", nb, NB);
    endtask

    initial begin
        void'($urandom(32'd4242));
        run_full();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) rst_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            repeat ($urandom_range(2800, 40)) @(negedge clk);
            run_full();   // R10: interrupted run restarts from scratch
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule